// File: doc/BRIEF.md
# Preloaded Timer Time Base

This block is the counting core of a general-purpose timer. A 16-bit up-counter is stepped by a programmable divider. It runs from zero up to an active reload limit, falls back to zero and reports an overflow. The divider ratio and the reload limit are written into holding registers. They reach the active copies only on an update event, so software can retune a running timer without producing a mixed period. The reload limit can also be made to take effect at once.

Software drives the block through a one-cycle write port. The select code picks the target: the control word, the counter, the divider holding register, the reload holding register, the software-update trigger or the update flag. The block returns the live count and a one-clock pulse each time the count moves, for channel logic downstream. It also returns a one-clock update-event pulse, a sticky update flag and an interrupt line, which is the flag masked by an enable bit.

Top module: `preload_timebase`

## Requirements
- R1: With active divider value D (select code 2 writes the holding copy), the counter advances once every D+1 clocks while running, and `tick_o` is high for exactly the clocks in which the counter advances.
- R2: The counter steps from 0 up to the active reload value L, then returns to 0 on the next advance. That wrap is an overflow.
- R3: A value written to the divider holding register changes the advance rate only after the next update event.
- R4: An overflow produces a one-clock `upd_o` pulse and sets the update flag when control bit 1 (update block) is 0.
- R5: Reload writes (select code 3) go straight to the active limit when control bit 3 (reload buffering) is 0. When it is 1, the value waits and becomes active at the next update event.
- R6: Writing select code 4 with data bit 0 set raises an internal strobe for one clock. In that clock `upd_o` is high and no advance happens. At its end the counter and the divider count are cleared and the strobe drops by itself.
- R7: While control bit 1 is 1, no update event occurs and the active divider and reload values hold. A software update still clears the counter and the divider count.
- R8: While control bit 2 is 1, a software update reloads the active registers but leaves the update flag unchanged. An overflow still sets it.
- R9: After a control write that sets bit 0 (run), the counter does not move in the write clock and takes its first step in the clock after it.
- R10: While the active reload value is 0, the counter does not advance and `tick_o` stays low. A direct counter write (select code 1) still loads it.
- R11: After reset the counter, the divider values and the flag are 0, and both reload copies are 0xFFFF.
- R12: The update flag stays set until a write of select code 5 with data bit 0 cleared. A write with bit 0 set has no effect. `irq_o` equals the flag ANDed with control bit 4.
- R13: The control word is written with select code 0. Its fields are bit 0 run, bit 1 update block, bit 2 flag-on-overflow-only, bit 3 reload buffering and bit 4 interrupt enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_sel | input | 3 | Write target select code |
| wr_data | input | 16 | Write data |
| cnt_o | output | 16 | Current counter value |
| tick_o | output | 1 | High in a clock where the counter advances |
| upd_o | output | 1 | Update-event pulse |
| uflag_o | output | 1 | Sticky update flag |
| irq_o | output | 1 | Update flag gated by interrupt enable |

## Verification
The embedded properties assume that reset is held low for at least one rising edge before any other activity. They also assume that only the six defined select codes are used. They do not assume any ordering between a flag-clear write and an overflow, because a set is taken to win over a clear in the same clock. The stimulus leaves the block stopped whenever it clears the flag for a directed check. It also never writes the counter in the clock that carries a software update. The per-clock reference model covers every other case, including writes to holding registers while the counter runs.

// File: rtl/tbu_pkg.sv
// Package: shared select codes and control-word layout for the time base.
// Assumes: select codes outside the enum are never driven.
package tbu_pkg;

    typedef enum logic [2:0] {
        SEL_CTRL   = 3'd0,
        SEL_COUNT  = 3'd1,
        SEL_DIV    = 3'd2,
        SEL_RELOAD = 3'd3,
        SEL_TRIG   = 3'd4,
        SEL_FLAG   = 3'd5
    } tbu_sel_e;

    // Packed MSB first: bit4 irq_en ... bit0 run (R13).
    typedef struct packed {
        logic irq_en;
        logic reload_buf;
        logic ovf_only;
        logic upd_block;
        logic run;
    } tbu_ctrl_t;

    localparam int CTRL_W = $bits(tbu_ctrl_t);

endpackage

// File: rtl/tbu_prescaler.sv
// Module: divider that produces a carry once every (active value + 1) clocks.
// Assumes: the active value is only loaded on an update event, which
// always coincides with the divider count returning to zero.
module tbu_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             sw_clr,
    input  logic             upd_evt,
    input  logic             div_wr,
    input  logic [PSC_W-1:0] div_data,
    output logic             carry
);

    logic [PSC_W-1:0] div_pre;
    logic [PSC_W-1:0] div_act;
    logic [PSC_W-1:0] pc;

    assign carry = run && (pc == div_act);

    // Holding register: takes every software write.
    always_ff @(posedge clk) begin
        if (!rst_n)      div_pre <= '0;
        else if (div_wr) div_pre <= div_data;
    end

    // Active register: copied from holding only on an update event.
    always_ff @(posedge clk) begin
        if (!rst_n)       div_act <= '0;
        else if (upd_evt) div_act <= div_pre;
    end

    // Divider count: cleared by software update, wraps on carry.
    always_ff @(posedge clk) begin
        if (!rst_n)     pc <= '0;
        else if (sw_clr) pc <= '0;
        else if (run)    pc <= carry ? '0 : pc + 1'b1;
    end

    // R1: divider count never passes the active limit
    p_pc_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pc <= div_act);

    // R3: active divider changes only on an update event
    p_div_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_evt |=> $stable(div_act));

endmodule

// File: rtl/tbu_counter.sv
// Module: up-counter with reload limit, holding copy and active copy.
// Assumes: carry comes from the divider; sw_clr has priority over writes.
module tbu_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             carry,
    input  logic             sw_clr,
    input  logic             upd_evt,
    input  logic             reload_buf,
    input  logic             cnt_wr,
    input  logic             reload_wr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt,
    output logic             tick,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] RELOAD_RST = '1;

    logic [CNT_W-1:0] reload_pre;
    logic [CNT_W-1:0] reload_act;
    logic             limit_zero;

    assign limit_zero = (reload_act == '0);
    assign tick       = carry && !limit_zero && !sw_clr && !cnt_wr;
    assign ovf        = tick && (cnt == reload_act);

    // Holding reload register: takes every reload write.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload_pre <= RELOAD_RST;
        else if (reload_wr) reload_pre <= wr_data;
    end

    // Active reload: direct write when unbuffered, else copy on update.
    always_ff @(posedge clk) begin
        if (!rst_n)                       reload_act <= RELOAD_RST;
        else if (reload_wr && !reload_buf) reload_act <= wr_data;
        else if (upd_evt)                 reload_act <= reload_pre;
    end

    // Counter: clear, direct load, or step with wrap at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (sw_clr) cnt <= '0;
        else if (cnt_wr) cnt <= wr_data;
        else if (tick)   cnt <= ovf ? '0 : cnt + 1'b1;
    end

    // R2: an overflow returns the counter to zero
    p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cnt == '0));

    // R10: zero limit freezes the counter
    p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_zero && !sw_clr && !cnt_wr) |=> $stable(cnt));

    // R5: active reload moves only on a direct write or an update
    p_reload_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_evt && !(reload_wr && !reload_buf)) |=> $stable(reload_act));

    // R6: software update leaves the counter at zero
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sw_clr |=> (cnt == '0));

endmodule

// File: rtl/tbu_update_ctrl.sv
// Module: control word, software update strobe, update event and flag.
// Assumes: ovf comes from the counter and excludes the strobe clock.
module tbu_update_ctrl
    import tbu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  tbu_sel_e          wr_sel,
    input  logic [CTRL_W-1:0] wr_bits,
    input  logic              ovf,
    output tbu_ctrl_t         ctrl,
    output logic              sw_upd,
    output logic              upd_evt,
    output logic              uflag,
    output logic              irq
);

    logic flag_set;
    logic flag_clr;
    logic trig_wr;

    assign trig_wr  = wr_en && (wr_sel == SEL_TRIG);
    assign upd_evt  = (ovf || sw_upd) && !ctrl.upd_block;
    assign flag_set = !ctrl.upd_block && (ovf || (sw_upd && !ctrl.ovf_only));
    assign flag_clr = wr_en && (wr_sel == SEL_FLAG) && !wr_bits[0];
    assign irq      = uflag && ctrl.irq_en;

    // Control word register.
    always_ff @(posedge clk) begin
        if (!rst_n)                            ctrl <= '0;
        else if (wr_en && wr_sel == SEL_CTRL) ctrl <= tbu_ctrl_t'(wr_bits);
    end

    // Software update strobe: lasts one clock after the trigger write.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_upd <= 1'b0;
        else        sw_upd <= trig_wr && wr_bits[0];
    end

    // Sticky flag: set wins over a clear in the same clock.
    always_ff @(posedge clk) begin
        if (!rst_n)        uflag <= 1'b0;
        else if (flag_set) uflag <= 1'b1;
        else if (flag_clr) uflag <= 1'b0;
    end

    // R7: blocked updates never reach the output
    p_block_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.upd_block |-> !upd_evt);

    // R12: flag holds until an explicit clear
    p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (uflag && !flag_clr) |=> uflag);

    // R8: silent software update does not raise a clear flag
    p_silent_sw_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_upd && ctrl.ovf_only && !ovf && !uflag) |=> !uflag);

    // R6: strobe clears itself when no new trigger arrives
    p_strobe_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_upd && !trig_wr) |=> !sw_upd);

endmodule

// File: rtl/preload_timebase.sv
// Module: top of the preloaded time base; wires divider, counter and
// update control together and decodes the write port.
// Assumes: one write per clock, synchronous active-low reset.
module preload_timebase
    import tbu_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [15:0]      wr_data,
    output logic [CNT_W-1:0] cnt_o,
    output logic             tick_o,
    output logic             upd_o,
    output logic             uflag_o,
    output logic             irq_o
);

    localparam int DATA_W = 16;

    tbu_sel_e  sel;
    tbu_ctrl_t ctrl;
    logic      carry;
    logic      sw_upd;
    logic      upd_evt;
    logic      ovf;
    logic      tick;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_data;
    logic [PSC_W-1:0] div_data;

    assign sel = tbu_sel_e'(wr_sel);

    // Fit the write data to each unit width.
    generate
        if (CNT_W >= DATA_W) begin : g_cnt_wide
            assign cnt_data = CNT_W'(wr_data);
        end else begin : g_cnt_narrow
            assign cnt_data = wr_data[CNT_W-1:0];
        end
        if (PSC_W >= DATA_W) begin : g_psc_wide
            assign div_data = PSC_W'(wr_data);
        end else begin : g_psc_narrow
            assign div_data = wr_data[PSC_W-1:0];
        end
    endgenerate

    tbu_update_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (sel),
        .wr_bits (wr_data[CTRL_W-1:0]),
        .ovf     (ovf),
        .ctrl    (ctrl),
        .sw_upd  (sw_upd),
        .upd_evt (upd_evt),
        .uflag   (uflag_o),
        .irq     (irq_o)
    );

    tbu_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl.run),
        .sw_clr   (sw_upd),
        .upd_evt  (upd_evt),
        .div_wr   (wr_en && sel == SEL_DIV),
        .div_data (div_data),
        .carry    (carry)
    );

    tbu_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .carry      (carry),
        .sw_clr     (sw_upd),
        .upd_evt    (upd_evt),
        .reload_buf (ctrl.reload_buf),
        .cnt_wr     (wr_en && sel == SEL_COUNT),
        .reload_wr  (wr_en && sel == SEL_RELOAD),
        .wr_data    (cnt_data),
        .cnt        (cnt),
        .tick       (tick),
        .ovf        (ovf)
    );

    assign cnt_o  = cnt;
    assign tick_o = tick;
    assign upd_o  = upd_evt;

    // R9: a stopped divider gives no advance
    p_stopped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.run |-> !tick_o);

endmodule

// File: tb/preload_timebase_tb.sv
`timescale 1ns/1ps
module preload_timebase_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] cnt_o;
    logic        tick_o, upd_o, uflag_o, irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    preload_timebase u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cnt_o(cnt_o), .tick_o(tick_o),
        .upd_o(upd_o), .uflag_o(uflag_o), .irq_o(irq_o)
    );

    // Behavioural reference state.
    int m_cnt, m_pc, m_div, m_divp, m_lim, m_limp;
    bit m_run, m_blk, m_ovfonly, m_buf, m_ie, m_ug, m_flag;
    int e_cnt; bit e_tick, e_upd, e_flag, e_irq, e_ovf;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_pc = 0; m_div = 0; m_divp = 0;
        m_lim = 16'hFFFF; m_limp = 16'hFFFF;
        m_run = 0; m_blk = 0; m_ovfonly = 0; m_buf = 0; m_ie = 0;
        m_ug = 0; m_flag = 0;
    endtask

    task automatic model_out(input bit we, input int sel);
        bit carry;
        carry  = m_run && (m_pc == m_div);
        e_tick = carry && (m_lim != 0) && !m_ug && !(we && sel == 1);
        e_ovf  = e_tick && (m_cnt == m_lim);
        e_upd  = (e_ovf || m_ug) && !m_blk;
        e_cnt  = m_cnt; e_flag = m_flag; e_irq = m_flag && m_ie;
    endtask

    task automatic model_next(input bit we, input int sel, input int d);
        bit carry, setf;
        carry = m_run && (m_pc == m_div);
        setf  = !m_blk && (e_ovf || (m_ug && !m_ovfonly));
        if (m_ug) m_pc = 0; else if (m_run) m_pc = carry ? 0 : m_pc + 1;
        if (m_ug) m_cnt = 0;
        else if (we && sel == 1) m_cnt = d;
        else if (e_tick) m_cnt = e_ovf ? 0 : m_cnt + 1;
        if (e_upd) m_div = m_divp;
        if (we && sel == 3 && !m_buf) m_lim = d;
        else if (e_upd) m_lim = m_limp;
        if (we && sel == 2) m_divp = d;
        if (we && sel == 3) m_limp = d;
        if (setf) m_flag = 1;
        else if (we && sel == 5 && d[0] == 0) m_flag = 0;
        m_ug = we && sel == 4 && d[0];
        if (we && sel == 0) begin
            m_run = d[0]; m_blk = d[1]; m_ovfonly = d[2];
            m_buf = d[3]; m_ie = d[4];
        end
    endtask

    // One clock: drive, compare outputs against the model, advance.
    task automatic step(input bit we, input int sel, input int d);
        wr_en = we; wr_sel = sel[2:0]; wr_data = d[15:0];
        model_out(we, sel);
        #1;
        chk("R2", int'(cnt_o), e_cnt);
        chk("R1", int'(tick_o), int'(e_tick));
        chk("R4", int'(upd_o), int'(e_upd));
        chk("R12", int'(uflag_o), int'(e_flag));
        chk("R12", int'(irq_o), int'(e_irq));
        model_next(we, sel, d);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0);
    endtask

    task automatic wr(input int sel, input int d);
        step(1, sel, d);
    endtask

    initial begin : watchdog
        #(5.0 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        int n;
        int mx;
        repeat (3) @(posedge clk);
        @(negedge clk);
        model_reset();
        // R11 reset state
        chk("R11", int'(cnt_o), 0);
        chk("R11", int'(uflag_o), 0);
        chk("R11", int'(upd_o), 0);
        chk("R11", int'(irq_o), 0);
        rst_n = 1'b1;

        // R5 unbuffered reload, R9 R13 start delay via control word
        wr(3, 5);
        wr(0, 16'h01);
        chk("R9 R13", int'(cnt_o), 0);
        idle(1);
        chk("R9", int'(cnt_o), 1);
        idle(12);
        chk("R4", int'(uflag_o), 1);

        // R12 interrupt gating and flag clearing
        wr(0, 16'h11);
        chk("R12", int'(irq_o), 1);
        wr(0, 16'h10);
        wr(5, 0);
        chk("R12", int'(uflag_o), 0);
        wr(5, 1);
        chk("R12", int'(uflag_o), 0);
        chk("R12", int'(irq_o), 0);

        // R3 divider preload and R6 software update
        wr(2, 2);
        wr(0, 16'h11);
        idle(4);
        wr(4, 1);
        chk("R6", int'(upd_o), 1);
        idle(1);
        chk("R6", int'(cnt_o), 0);
        chk("R6", int'(upd_o), 0);
        n = 0;
        for (int i = 0; i < 30; i++) begin
            if (tick_o) n++;
            step(0, 0, 0);
        end
        chk("R3", n, 10);

        // R5 buffered reload waits for update
        wr(0, 16'h19);
        wr(3, 2);
        idle(40);
        mx = 0;
        for (int i = 0; i < 12; i++) begin
            if (int'(cnt_o) > mx) mx = int'(cnt_o);
            step(0, 0, 0);
        end
        chk("R5", mx, 2);

        // R7 update block
        wr(0, 16'h1B);
        wr(2, 0);
        wr(3, 4);
        n = 0;
        for (int i = 0; i < 30; i++) begin
            if (upd_o) n++;
            step(0, 0, 0);
        end
        chk("R7", n, 0);
        wr(4, 1);
        chk("R7", int'(upd_o), 0);
        idle(1);
        chk("R7", int'(cnt_o), 0);
        n = 0;
        for (int i = 0; i < 30; i++) begin
            if (tick_o) n++;
            step(0, 0, 0);
        end
        chk("R7", n, 10);

        // R8 flag-silent software update
        wr(0, 16'h0C);
        wr(5, 0);
        wr(4, 1);
        chk("R8", int'(upd_o), 1);
        idle(1);
        chk("R8", int'(uflag_o), 0);
        wr(0, 16'h0D);
        idle(10);
        chk("R8", int'(uflag_o), 1);

        // R10 zero limit freezes the counter
        wr(0, 16'h01);
        wr(3, 0);
        wr(1, 7);
        n = 0;
        for (int i = 0; i < 10; i++) begin
            if (tick_o) n++;
            step(0, 0, 0);
        end
        chk("R10", int'(cnt_o), 7);
        chk("R10", n, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule